// File: doc/BRIEF.md
# Clock-Enable Paced SPI Master

This block is the controller side of a point-to-point SPI link with exactly one slave. On a start request it loads a parallel word, shifts it out most significant bit first on `mosi`, and collects the same number of bits from `miso` into a parallel read word. It does not drive a slave-select line. The surrounding logic asserts the select before issuing start and releases it after ready returns.

Serial timing is set by a single-cycle enable input. Every system clock cycle with `step_en` high moves `sclk` by half a period, so the serial clock runs at half the enabled-cycle rate. With `step_en` tied high, `sclk` is half the system clock. The clock polarity and phase come from the `cpol` and `cpha` inputs and are captured when a transfer is accepted. The word width is the parameter `W`, which defaults to 8 and must be at least 2.

The sequencer has three states. `ST_IDLE` waits for start. `ST_LEAD` waits to produce the first edge of a bit. `ST_TRAIL` waits to produce the second edge. The transitions are: `ST_IDLE` to `ST_LEAD` on an accepted start; `ST_LEAD` to `ST_TRAIL` on an enabled cycle; `ST_TRAIL` to `ST_LEAD` on an enabled cycle when bits remain; and `ST_TRAIL` to `ST_IDLE` on the enabled cycle that ends the last bit. Keep `cpol` and `cpha` steady from start until ready returns.

Top module: `spi_word_master`

## Requirements
- R1: While `rst` (synchronous, active high) is asserted, at every clock edge `ready` becomes 1, `sclk` takes the value of `cpol`, and both `mosi` and `rx_word` become 0.
- R2: While `ready` is high, `sclk` equals the `cpol` value sampled at the previous clock edge.
- R3: A clock edge with `start` and `ready` both high accepts a transfer using the `tx_word` present at that edge. `ready` is 0 after that edge and stays 0 until the transfer completes.
- R4: While a transfer is in progress, `sclk` toggles at every clock edge where `step_en` is 1 and holds at every edge where it is 0. A transfer ends after exactly 2*W enabled edges following acceptance.
- R5: With `cpha`=0, data is sent MSB first. The MSB of the word appears on `mosi` right after the accepting edge. `miso` is sampled at the first `sclk` edge of each bit. `mosi` moves to the next bit at the second `sclk` edge of each bit, except after the last bit, where it holds.
- R6: With `cpha`=1, `mosi` takes each bit (MSB first) at the first `sclk` edge of that bit, and `miso` is sampled at the second `sclk` edge. Between the accepting edge and the first `sclk` edge, `mosi` keeps its earlier value.
- R7: `ready` returns to 1 at the same edge that drives `sclk` back to its idle level, ending the final bit. At that point `rx_word` holds the W received bits, the first received bit in bit W-1.
- R8: `rx_word` changes only at the edge where `ready` returns to 1.
- R9: `start` and `tx_word` have no effect while a transfer is in progress. The bits on `mosi` and the length of the transfer still follow the word captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Half-period advance enable, aligned to clk |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on first edge; 1: sample on second edge |
| start | input | 1 | Transfer request, accepted while ready is high |
| tx_word | input | W | Word to send |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ready | output | 1 | Idle, and read word valid after a transfer |
| rx_word | output | W | Last word received |

## Verification
The bound checker enforces several properties on every cycle. It checks that `sclk` follows `cpol` while idle, that an accepted start drops ready, and that `sclk` toggles on exactly the enabled busy cycles. It also checks that ready only returns together with an `sclk` edge and that `rx_word` is frozen outside that edge. Other behaviours can only be shown by the bench scenarios: the bit order on `mosi` in each phase mode, the sampling point of `miso`, the assembled read word, and the fact that a start issued mid-transfer is ignored. The bench shows these by running every mode under continuous, sparse and irregular enable patterns against its reference model.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL
    } xfer_state_t;

    typedef struct packed {
        logic cpol;
        logic cpha;
    } spi_mode_t;

endpackage

// File: rtl/spi_word_seq.sv
module spi_word_seq
    import spi_word_pkg::*;
#(
    parameter int W = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      step_en,
    input  logic      start,
    input  spi_mode_t mode_in,
    output logic      accept_o,
    output logic      lead_o,
    output logic      trail_o,
    output logic      final_o,
    output logic      run_cpha_o,
    output logic      sclk_o,
    output logic      ready_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    xfer_state_t    state_q, state_d;
    logic [CW-1:0]  bit_q;
    logic           run_cpha_q;
    logic           sclk_q;
    logic           ready_q;
    logic           last_bit;

    assign last_bit = (bit_q == LAST_IDX);
    assign accept_o = (state_q == ST_IDLE) && start;
    assign lead_o   = (state_q == ST_LEAD) && step_en;
    assign trail_o  = (state_q == ST_TRAIL) && step_en;
    assign final_o  = trail_o && last_bit;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept_o) state_d = ST_LEAD;
            ST_LEAD:  if (step_en)  state_d = ST_TRAIL;
            ST_TRAIL: if (step_en)  state_d = last_bit ? ST_IDLE : ST_LEAD;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // registered outputs and bit counter
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q     <= mode_in.cpol;
            ready_q    <= 1'b1;
            bit_q      <= '0;
            run_cpha_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sclk_q <= mode_in.cpol;
                    if (accept_o) begin
                        ready_q    <= 1'b0;
                        bit_q      <= '0;
                        run_cpha_q <= mode_in.cpha;
                    end
                end
                ST_LEAD: begin
                    if (step_en) sclk_q <= ~sclk_q;
                end
                ST_TRAIL: begin
                    if (step_en) begin
                        sclk_q <= ~sclk_q;
                        if (last_bit) ready_q <= 1'b1;
                        else          bit_q   <= bit_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign run_cpha_o = run_cpha_q;
    assign sclk_o     = sclk_q;
    assign ready_o    = ready_q;

endmodule

// File: rtl/spi_word_datapath.sv
module spi_word_datapath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         accept,
    input  logic         cpha_now,
    input  logic         cpha_run,
    input  logic         lead,
    input  logic         trail,
    input  logic         final_bit,
    input  logic         miso,
    input  logic [W-1:0] tx_word,
    output logic         mosi,
    output logic [W-1:0] rx_word
);
    logic [W-1:0] tx_sh;
    logic [W-1:0] rx_sh;
    logic [W-1:0] rx_in;
    logic         mosi_q;
    logic [W-1:0] rx_word_q;

    assign rx_in = {rx_sh[W-2:0], miso};

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh     <= '0;
            rx_sh     <= '0;
            mosi_q    <= 1'b0;
            rx_word_q <= '0;
        end else if (accept) begin
            tx_sh <= tx_word;
            rx_sh <= '0;
            if (!cpha_now) mosi_q <= tx_word[W-1];
        end else if (lead) begin
            if (!cpha_run) rx_sh  <= rx_in;
            else           mosi_q <= tx_sh[W-1];
        end else if (trail) begin
            tx_sh <= {tx_sh[W-2:0], 1'b0};
            if (!cpha_run) begin
                if (final_bit) rx_word_q <= rx_sh;
                else           mosi_q    <= tx_sh[W-2];
            end else begin
                rx_sh <= rx_in;
                if (final_bit) rx_word_q <= rx_in;
            end
        end
    end

    assign mosi    = mosi_q;
    assign rx_word = rx_word_q;

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spi_word_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_en,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         start,
    input  logic [W-1:0] tx_word,
    input  logic         miso,
    output logic         sclk,
    output logic         mosi,
    output logic         ready,
    output logic [W-1:0] rx_word
);
    spi_mode_t mode_now;
    logic accept, lead, trail, final_bit, cpha_run;

    assign mode_now = '{cpol: cpol, cpha: cpha};

    spi_word_seq #(.W(W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .step_en    (step_en),
        .start      (start),
        .mode_in    (mode_now),
        .accept_o   (accept),
        .lead_o     (lead),
        .trail_o    (trail),
        .final_o    (final_bit),
        .run_cpha_o (cpha_run),
        .sclk_o     (sclk),
        .ready_o    (ready)
    );

    spi_word_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .cpha_now  (cpha),
        .cpha_run  (cpha_run),
        .lead      (lead),
        .trail     (trail),
        .final_bit (final_bit),
        .miso      (miso),
        .tx_word   (tx_word),
        .mosi      (mosi),
        .rx_word   (rx_word)
    );

endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         step_en,
    input logic         cpol,
    input logic         start,
    input logic         sclk,
    input logic         ready,
    input logic [W-1:0] rx_word
);
    assert_idle_follows_cpol_R2: assert property (@(posedge clk) disable iff (rst)
        ready |=> (sclk == $past(cpol)));

    assert_start_drops_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> !ready);

    assert_busy_enabled_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        (!ready && step_en) |=> (sclk != $past(sclk)));

    assert_busy_disabled_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!ready && !step_en) |=> ($stable(sclk) && !ready));

    assert_ready_with_final_edge_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (sclk != $past(sclk)));

    assert_read_word_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$rose(ready) |-> $stable(rx_word));
endmodule

bind spi_word_master spi_word_master_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .cpol    (cpol),
    .start   (start),
    .sclk    (sclk),
    .ready   (ready),
    .rx_word (rx_word)
);

// File: tb/spi_word_master_test.sv
module spi_word_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int WATCHDOG = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         step_en = 1'b1;
    logic         cpol = 1'b0;
    logic         cpha = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         miso = 1'b0;
    wire          sclk, mosi, ready;
    wire  [W-1:0] rx_word;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int en_kind = 0;
    logic [W-1:0] slave_pat = '0;

    spi_word_master #(.W(W)) uut (
        .clk(clk), .rst(rst), .step_en(step_en), .cpol(cpol), .cpha(cpha),
        .start(start), .tx_word(tx_word), .miso(miso),
        .sclk(sclk), .mosi(mosi), .ready(ready), .rx_word(rx_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model, counted in half periods
    logic         started = 1'b0;
    logic         m_busy = 1'b0;
    int           m_half = 0;
    int           m_taken = 0;
    int           m_enabled = 0;
    logic         m_cpol = 1'b0, m_cpha = 1'b0;
    logic [W-1:0] m_tx = '0;
    logic [W-1:0] m_acc = '0;
    logic         e_sclk = 1'b0, e_mosi = 1'b0, e_ready = 1'b1;
    logic [W-1:0] e_rx = '0;

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_busy = 1'b0; e_ready = 1'b1; e_sclk = cpol; e_mosi = 1'b0; e_rx = '0;
        end else if (!m_busy) begin
            e_sclk = cpol;
            if (start) begin
                m_busy = 1'b1; m_half = 0; m_taken = 0; m_enabled = 0;
                e_ready = 1'b0; m_tx = tx_word; m_cpol = cpol; m_cpha = cpha; m_acc = '0;
                if (!cpha) e_mosi = tx_word[W-1];
            end
        end else if (step_en) begin
            int b;
            m_half = m_half + 1;
            m_enabled = m_enabled + 1;
            b = (m_half - 1) / 2;
            e_sclk = m_cpol ^ (m_half % 2 == 1);
            if (m_half % 2 == 1) begin
                if (!m_cpha) begin m_acc = {m_acc[W-2:0], miso}; m_taken++; end
                else e_mosi = m_tx[W-1-b];
            end else begin
                if (!m_cpha) begin if (b < W-1) e_mosi = m_tx[W-2-b]; end
                else begin m_acc = {m_acc[W-2:0], miso}; m_taken++; end
            end
            if (m_half == 2*W) begin
                m_busy = 1'b0; e_ready = 1'b1; e_rx = m_acc;
            end
        end
    end

    // slave data and enable pattern, driven away from the active edge
    always @(negedge clk) begin
        miso <= (m_busy && m_taken < W) ? slave_pat[W-1-m_taken] : 1'b0;
        case (en_kind)
            0:       step_en <= 1'b1;
            1:       step_en <= (cyc % 3 == 0);
            default: step_en <= 1'($urandom % 2);
        endcase
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (ready !== e_ready) begin
                errors++;
                $display("FAIL R3/R7 ready: actual %b expected %b at cycle %0d", ready, e_ready, cyc);
            end
            checks++;
            if (sclk !== e_sclk) begin
                errors++;
                $display("FAIL %s sclk: actual %b expected %b at cycle %0d",
                         e_ready ? "R1/R2" : "R4", sclk, e_sclk, cyc);
            end
            checks++;
            if (mosi !== e_mosi) begin
                errors++;
                $display("FAIL %s mosi: actual %b expected %b at cycle %0d",
                         m_cpha ? "R6/R9" : "R5/R9", mosi, e_mosi, cyc);
            end
            checks++;
            if (rx_word !== e_rx) begin
                errors++;
                $display("FAIL R8 rx_word: actual %h expected %h at cycle %0d", rx_word, e_rx, cyc);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL R4 watchdog: actual %0d cycles expected at most %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    task automatic xfer(input logic pol, input logic pha, input logic [W-1:0] tx,
                        input logic [W-1:0] pat, input int kind, input bit poke);
        int waited;
        @(negedge clk);
        cpol = pol; cpha = pha; en_kind = kind; slave_pat = pat;
        @(negedge clk);
        start = 1'b1; tx_word = tx;
        @(negedge clk);
        start = 1'b0;
        // R3: ready is low right after acceptance
        checks++;
        if (ready !== 1'b0) begin
            errors++;
            $display("FAIL R3 ready after start: actual %b expected 0", ready);
        end
        waited = 0;
        while (ready !== 1'b1 && waited < 20000) begin
            if (poke && waited == 2) begin
                start = 1'b1; tx_word = ~tx;   // R9: must be ignored
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        start = 1'b0;
        checks++;
        if (rx_word !== pat) begin
            errors++;
            $display("FAIL R7 rx_word: actual %h expected %h", rx_word, pat);
        end
        checks++;
        if (m_enabled != 2*W) begin
            errors++;
            $display("FAIL R4 enabled edges: actual %0d expected %0d", m_enabled, 2*W);
        end
    endtask

    initial begin
        rst = 1'b1; cpol = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state with cpol = 1
        checks++;
        if (ready !== 1'b1 || sclk !== 1'b1 || mosi !== 1'b0 || rx_word !== '0) begin
            errors++;
            $display("FAIL R1 reset: actual r%b s%b m%b x%h expected r1 s1 m0 x00",
                     ready, sclk, mosi, rx_word);
        end
        rst = 1'b0;
        // R2: idle sclk follows cpol one edge later
        cpol = 1'b0;
        @(negedge clk);
        checks++;
        if (sclk !== 1'b0) begin
            errors++;
            $display("FAIL R2 idle sclk: actual %b expected 0", sclk);
        end
        xfer(1'b0, 1'b0, 8'hA5, 8'h3C, 0, 1'b0);
        xfer(1'b0, 1'b1, 8'h96, 8'hC3, 0, 1'b0);
        xfer(1'b1, 1'b0, 8'h81, 8'h7E, 1, 1'b1);
        xfer(1'b1, 1'b1, 8'h5A, 8'hF0, 1, 1'b1);
        xfer(1'b0, 1'b1, 8'h01, 8'h80, 2, 1'b1);
        xfer(1'b1, 1'b0, 8'hFE, 8'h0F, 2, 1'b0);
        xfer(1'b0, 1'b0, 8'h00, 8'hFF, 2, 1'b1);
        xfer(1'b1, 1'b1, 8'hFF, 8'h00, 0, 1'b0);
        // R8: read word held across idle cycles
        repeat (5) @(negedge clk);
        checks++;
        if (rx_word !== 8'h00) begin
            errors++;
            $display("FAIL R8 held rx_word: actual %h expected 00", rx_word);
        end
        finish_run();
    end
endmodule